// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which operating mode a small microcontroller is in and turns that mode into clock and oscillator controls. From full-speed operation the CPU can move to a divided-clock mode, park itself until an interrupt is acknowledged (with or without the divided clock), shut everything down in stop, or freeze the whole machine in halt. The block turns each mode into enables for the CPU clock, the peripheral clock, the oscillator and the watchdog counter. It also drives a clock-divider select and a PLL source select.

Stop can only be reached through a protected write sequence to a one-bit control register, and only while the NMI pin is low. Any of the wake-up lines, or NMI, ends stop. The wake-up lines and NMI pass through a synchronizer first. The clocks then stay gated until the oscillator reports that it is running and a stabilization counter has expired. The machine then resumes in the mode it left, with the PLL deselected. Halt is refused while the watchdog is enabled and can only be left by reset.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset `mode_o` is 0 (full speed), the CPU, peripheral and oscillator enables are 1, `clk_div_sel_o` and `pll_sel_o` are 0, and `wdg_cnt_en_o` equals `wdg_enabled_i`.
- R2: From full speed a `slow_req_i` pulse moves to slow mode (`mode_o`=1, `clk_div_sel_o`=1), and a `run_req_i` pulse in slow mode returns to mode 0. Each change shows the cycle after the pulse.
- R3: A `wfi_req_i` pulse in full speed enters mode 2, where the CPU clock enable is 0 and the peripheral clock enable is 1. Wake-up lines do not end mode 2. `int_ack_i` returns to mode 0.
- R4: A `wfi_req_i` pulse in slow mode enters mode 3 (CPU clock off, peripheral clock on, divider on). `int_ack_i` returns to slow mode.
- R5: Stop (`mode_o`=4) is entered the cycle after the writes 1, 0, 1 through `stop_wr_en_i`/`stop_wr_bit_i` complete in mode 0 or 1 with `nmi_i` low. In stop the CPU, peripheral and oscillator enables are all 0.
- R6: A write that does not match the next expected bit returns the unlock sequence to its start without counting as a new first write. A completed sequence while `nmi_i` is high leaves the mode unchanged.
- R7: In stop, a pulse on any wake-up line or on `nmi_i` moves to mode 5 after the two-stage synchronizer, three cycles after the pulse starts. In mode 5 the oscillator is enabled and the CPU and peripheral clocks stay off.
- R8: In mode 5 the stabilization counter advances only in cycles with `osc_running_i` high. After `STAB_CYCLES` such cycles the block returns to mode 0, or to mode 1 if stop was entered from slow mode.
- R9: `pll_sel_o` follows `pll_wr_bit_i` on a `pll_wr_en_i` write in mode 0 or 1. It is cleared on stop entry and stays 0 after the wake-up until it is written again.
- R10: `wdg_cnt_en_o` is 0 in modes 4, 5 and 6, and equals `wdg_enabled_i` in every other mode.
- R11: A `halt_req_i` pulse in mode 0 or 1 enters halt (`mode_o`=6, all enables 0) only when `wdg_enabled_i` is 0. Otherwise it is ignored. Halt ignores every input except reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_req_i | input | 1 | Request full-speed mode (strobe) |
| slow_req_i | input | 1 | Request slow mode (strobe) |
| wfi_req_i | input | 1 | Request wait-for-interrupt (strobe) |
| halt_req_i | input | 1 | Request halt (strobe) |
| stop_wr_en_i | input | 1 | Write strobe to the stop control bit |
| stop_wr_bit_i | input | 1 | Value written to the stop control bit |
| pll_wr_en_i | input | 1 | Write strobe to the PLL select bit |
| pll_wr_bit_i | input | 1 | Value written to the PLL select bit |
| int_ack_i | input | 1 | Interrupt acknowledged |
| wake_lines_i | input | N_WAKE | External wake-up lines, active high |
| nmi_i | input | 1 | NMI pin, active high |
| wdg_enabled_i | input | 1 | Watchdog is enabled |
| osc_running_i | input | 1 | Oscillator is oscillating |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral and interrupt-controller clock enable |
| clk_div_sel_o | output | 1 | Select the divided clock |
| pll_sel_o | output | 1 | Select the PLL output as clock source |
| osc_en_o | output | 1 | Oscillator enable |
| wdg_cnt_en_o | output | 1 | Watchdog count enable |
| mode_o | output | 3 | Current mode: 0 run, 1 slow, 2 wfi, 3 low-power wfi, 4 stop, 5 stabilizing, 6 halt |

## Verification
The assertions check, on every cycle, the relations that hold between the mode and the enables. Stop and halt keep every clock off, the watchdog is frozen outside the running modes, and the PLL stays deselected through stop and stabilization. They also check that halt never releases and that every entry into halt or stop and every exit from stabilization was allowed in the cycle before. Only the bench scenarios can show the order-dependent behaviour. These are the abort of a half-finished unlock sequence, the exact stabilization length with oscillator gaps, the return to slow rather than full speed, and the wake-up latency through the synchronizer.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [2:0] {
      MODE_RUN   = 3'd0,
      MODE_SLOW  = 3'd1,
      MODE_WFI   = 3'd2,
      MODE_LPWFI = 3'd3,
      MODE_STOP  = 3'd4,
      MODE_WAKE  = 3'd5,
      MODE_HALT  = 3'd6
   } pwr_mode_e;

   typedef struct packed {
      logic cpu_en;
      logic per_en;
      logic div_sel;
      logic osc_en;
      logic wdg_run;
   } clk_ctrl_t;

   function automatic clk_ctrl_t mode_clocks(input pwr_mode_e m);
      clk_ctrl_t c;
      unique case (m)
         MODE_RUN:   c = '{cpu_en: 1'b1, per_en: 1'b1, div_sel: 1'b0, osc_en: 1'b1, wdg_run: 1'b1};
         MODE_SLOW:  c = '{cpu_en: 1'b1, per_en: 1'b1, div_sel: 1'b1, osc_en: 1'b1, wdg_run: 1'b1};
         MODE_WFI:   c = '{cpu_en: 1'b0, per_en: 1'b1, div_sel: 1'b0, osc_en: 1'b1, wdg_run: 1'b1};
         MODE_LPWFI: c = '{cpu_en: 1'b0, per_en: 1'b1, div_sel: 1'b1, osc_en: 1'b1, wdg_run: 1'b1};
         MODE_WAKE:  c = '{cpu_en: 1'b0, per_en: 1'b0, div_sel: 1'b0, osc_en: 1'b1, wdg_run: 1'b0};
         default:    c = '{cpu_en: 1'b0, per_en: 1'b0, div_sel: 1'b0, osc_en: 1'b0, wdg_run: 1'b0};
      endcase
      return c;
   endfunction

   function automatic logic cpu_active(input pwr_mode_e m);
      return (m == MODE_RUN) || (m == MODE_SLOW);
   endfunction

endpackage

// File: rtl/pwr_stop_unlock.sv
module pwr_stop_unlock #(
   parameter int                 SEQ_LEN     = 3,
   parameter logic [SEQ_LEN-1:0] SEQ_PATTERN = 3'b101
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic wr_en_i,
   input  logic wr_bit_i,
   output logic fire_o
);
   localparam int IDX_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

   logic [IDX_W-1:0] idx_q;
   logic             exp_bit;
   logic             match;

   // first write is compared against the most significant pattern bit
   assign exp_bit = SEQ_PATTERN[LAST_IDX - idx_q];
   assign match   = arm_i && wr_en_i && (wr_bit_i == exp_bit);
   assign fire_o  = match && (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (!arm_i) begin
         idx_q <= '0;
      end else if (wr_en_i) begin
         if (!match || fire_o) idx_q <= '0;
         else                  idx_q <= idx_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
   parameter int N_LINES     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] lines_i,
   input  logic               nmi_i,
   output logic               wake_o
);
   localparam int VEC_W = N_LINES + 1;

   logic [VEC_W-1:0] raw;
   logic [VEC_W-1:0] synced;

   assign raw = {nmi_i, lines_i};

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_sync
         logic [VEC_W-1:0] stage_q [SYNC_STAGES];
         for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else if (s == 0) stage_q[s] <= raw;
               else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
         end
         assign synced = stage_q[SYNC_STAGES-1];
      end
   endgenerate

   assign wake_o = |synced;
endmodule

// File: rtl/pwr_stab_timer.sv
module pwr_stab_timer #(
   parameter int STAB_CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic osc_ok_i,
   output logic done_o
);
   localparam int CNT_W = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   assign done_o = active_i && osc_ok_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!active_i || done_o) begin
         cnt_q <= '0;
      end else if (osc_ok_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run_req_i,
   input  logic      slow_req_i,
   input  logic      wfi_req_i,
   input  logic      halt_req_i,
   input  logic      unlock_fire_i,
   input  logic      nmi_i,
   input  logic      int_ack_i,
   input  logic      wake_i,
   input  logic      wdg_enabled_i,
   input  logic      stab_done_i,
   output pwr_mode_e mode_o,
   output logic      stop_entry_o
);
   pwr_mode_e mode_q, mode_d;
   logic      resume_slow_q, resume_slow_d;
   logic      halt_ok;
   logic      stop_ok;

   assign halt_ok      = halt_req_i && !wdg_enabled_i;
   assign stop_ok      = unlock_fire_i && !nmi_i;
   assign stop_entry_o = cpu_active(mode_q) && !halt_ok && stop_ok;

   always_comb begin
      mode_d        = mode_q;
      resume_slow_d = resume_slow_q;
      unique case (mode_q)
         MODE_RUN: begin
            if (halt_ok)         mode_d = MODE_HALT;
            else if (stop_ok)    begin mode_d = MODE_STOP; resume_slow_d = 1'b0; end
            else if (wfi_req_i)  mode_d = MODE_WFI;
            else if (slow_req_i) mode_d = MODE_SLOW;
         end
         MODE_SLOW: begin
            if (halt_ok)         mode_d = MODE_HALT;
            else if (stop_ok)    begin mode_d = MODE_STOP; resume_slow_d = 1'b1; end
            else if (wfi_req_i)  mode_d = MODE_LPWFI;
            else if (run_req_i)  mode_d = MODE_RUN;
         end
         MODE_WFI:   if (int_ack_i) mode_d = MODE_RUN;
         MODE_LPWFI: if (int_ack_i) mode_d = MODE_SLOW;
         MODE_STOP:  if (wake_i)    mode_d = MODE_WAKE;
         MODE_WAKE:  if (stab_done_i) mode_d = resume_slow_q ? MODE_SLOW : MODE_RUN;
         default:    mode_d = MODE_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q        <= MODE_RUN;
         resume_slow_q <= 1'b0;
      end else begin
         mode_q        <= mode_d;
         resume_slow_q <= resume_slow_d;
      end
   end

   assign mode_o = mode_q;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_mode_pkg::*;
#(
   parameter int                 N_WAKE      = 16,
   parameter int                 WAKE_SYNC   = 2,
   parameter int                 STAB_CYCLES = 20000,
   parameter int                 SEQ_LEN     = 3,
   parameter logic [SEQ_LEN-1:0] SEQ_PATTERN = 3'b101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_req_i,
   input  logic              slow_req_i,
   input  logic              wfi_req_i,
   input  logic              halt_req_i,
   input  logic              stop_wr_en_i,
   input  logic              stop_wr_bit_i,
   input  logic              pll_wr_en_i,
   input  logic              pll_wr_bit_i,
   input  logic              int_ack_i,
   input  logic [N_WAKE-1:0] wake_lines_i,
   input  logic              nmi_i,
   input  logic              wdg_enabled_i,
   input  logic              osc_running_i,
   output logic              cpu_clk_en_o,
   output logic              per_clk_en_o,
   output logic              clk_div_sel_o,
   output logic              pll_sel_o,
   output logic              osc_en_o,
   output logic              wdg_cnt_en_o,
   output logic [2:0]        mode_o
);
   generate
      if (N_WAKE < 1)       begin : g_bad_wake  $error("N_WAKE must be at least 1");      end
      if (WAKE_SYNC < 0)    begin : g_bad_sync  $error("WAKE_SYNC must not be negative"); end
      if (STAB_CYCLES < 2)  begin : g_bad_stab  $error("STAB_CYCLES must be at least 2"); end
      if (SEQ_LEN < 2)      begin : g_bad_seq   $error("SEQ_LEN must be at least 2");     end
   endgenerate

   pwr_mode_e mode;
   clk_ctrl_t ctl;
   logic      unlock_fire;
   logic      wake;
   logic      stab_done;
   logic      stop_entry;
   logic      pll_q;

   pwr_stop_unlock #(
      .SEQ_LEN     (SEQ_LEN),
      .SEQ_PATTERN (SEQ_PATTERN)
   ) i_unlock (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (cpu_active(mode)),
      .wr_en_i  (stop_wr_en_i),
      .wr_bit_i (stop_wr_bit_i),
      .fire_o   (unlock_fire)
   );

   pwr_wake_detect #(
      .N_LINES     (N_WAKE),
      .SYNC_STAGES (WAKE_SYNC)
   ) i_wake (
      .clk     (clk),
      .rst_n   (rst_n),
      .lines_i (wake_lines_i),
      .nmi_i   (nmi_i),
      .wake_o  (wake)
   );

   pwr_stab_timer #(
      .STAB_CYCLES (STAB_CYCLES)
   ) i_stab (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (mode == MODE_WAKE),
      .osc_ok_i (osc_running_i),
      .done_o   (stab_done)
   );

   pwr_mode_fsm i_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .run_req_i     (run_req_i),
      .slow_req_i    (slow_req_i),
      .wfi_req_i     (wfi_req_i),
      .halt_req_i    (halt_req_i),
      .unlock_fire_i (unlock_fire),
      .nmi_i         (nmi_i),
      .int_ack_i     (int_ack_i),
      .wake_i        (wake),
      .wdg_enabled_i (wdg_enabled_i),
      .stab_done_i   (stab_done),
      .mode_o        (mode),
      .stop_entry_o  (stop_entry)
   );

   // clock source falls back to the oscillator on stop entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                pll_q <= 1'b0;
      else if (stop_entry)                       pll_q <= 1'b0;
      else if (pll_wr_en_i && cpu_active(mode))  pll_q <= pll_wr_bit_i;
   end

   assign ctl           = mode_clocks(mode);
   assign cpu_clk_en_o  = ctl.cpu_en;
   assign per_clk_en_o  = ctl.per_en;
   assign clk_div_sel_o = ctl.div_sel;
   assign osc_en_o      = ctl.osc_en;
   assign wdg_cnt_en_o  = ctl.wdg_run && wdg_enabled_i;
   assign pll_sel_o     = pll_q;
   assign mode_o        = mode;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
   import pwr_mode_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       nmi_i,
   input logic       wdg_enabled_i,
   input logic       osc_running_i,
   input logic       cpu_clk_en_o,
   input logic       per_clk_en_o,
   input logic       pll_sel_o,
   input logic       osc_en_o,
   input logic       wdg_cnt_en_o,
   input logic [2:0] mode_o
);
   // R3
   wfi_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_WFI) |-> (!cpu_clk_en_o && per_clk_en_o));

   // R5
   stop_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_STOP) |-> (!cpu_clk_en_o && !per_clk_en_o && !osc_en_o));

   // R5
   stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_STOP && $past(mode_o) != MODE_STOP) |->
      (!$past(nmi_i) && ($past(mode_o) == MODE_RUN || $past(mode_o) == MODE_SLOW)));

   // R7
   wake_gating_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_WAKE) |-> (osc_en_o && !cpu_clk_en_o && !per_clk_en_o));

   // R8
   wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == MODE_WAKE && mode_o != MODE_WAKE) |->
      ($past(osc_running_i) && (mode_o == MODE_RUN || mode_o == MODE_SLOW)));

   // R9
   pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_STOP || mode_o == MODE_WAKE) |-> !pll_sel_o);

   // R10
   wdg_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_STOP || mode_o == MODE_WAKE || mode_o == MODE_HALT) |-> !wdg_cnt_en_o);

   // R11
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_HALT) |=> (mode_o == MODE_HALT));

   // R11
   halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == MODE_HALT && $past(mode_o) != MODE_HALT) |-> !$past(wdg_enabled_i));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk i_pwr_mode_seq_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .nmi_i         (nmi_i),
   .wdg_enabled_i (wdg_enabled_i),
   .osc_running_i (osc_running_i),
   .cpu_clk_en_o  (cpu_clk_en_o),
   .per_clk_en_o  (per_clk_en_o),
   .pll_sel_o     (pll_sel_o),
   .osc_en_o      (osc_en_o),
   .wdg_cnt_en_o  (wdg_cnt_en_o),
   .mode_o        (mode_o)
);

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
   localparam int STAB = 16;
   localparam int NW   = 16;

   localparam logic [3:0] OP_NOP  = 4'd0;
   localparam logic [3:0] OP_PLL  = 4'd1;
   localparam logic [3:0] OP_SLOW = 4'd2;
   localparam logic [3:0] OP_RUN  = 4'd3;
   localparam logic [3:0] OP_WFI  = 4'd4;
   localparam logic [3:0] OP_ACK  = 4'd5;
   localparam logic [3:0] OP_WAKE = 4'd6;
   localparam logic [3:0] OP_HALT = 4'd7;
   localparam logic [3:0] OP_STW  = 4'd8;
   localparam logic [3:0] OP_NMI  = 4'd9;

   // {op, arg, mode, cpu, per, div, pll}
   localparam int NV = 16;
   localparam logic [26:0] VEC [NV] = '{
      {OP_NOP,  16'h0000, 3'd0, 4'b1100},  // R1
      {OP_PLL,  16'h0001, 3'd0, 4'b1101},  // R9 select PLL
      {OP_SLOW, 16'h0000, 3'd1, 4'b1111},  // R2
      {OP_WFI,  16'h0000, 3'd3, 4'b0111},  // R4
      {OP_ACK,  16'h0000, 3'd1, 4'b1111},  // R4
      {OP_RUN,  16'h0000, 3'd0, 4'b1101},  // R2
      {OP_WFI,  16'h0000, 3'd2, 4'b0101},  // R3
      {OP_WAKE, 16'h0100, 3'd2, 4'b0101},  // R3 wake lines ignored
      {OP_ACK,  16'h0000, 3'd0, 4'b1101},  // R3
      {OP_HALT, 16'h0000, 3'd0, 4'b1101},  // R11 refused, watchdog on
      {OP_STW,  16'h0001, 3'd0, 4'b1101},  // R6 first 1
      {OP_STW,  16'h0001, 3'd0, 4'b1101},  // R6 wrong bit aborts
      {OP_STW,  16'h0000, 3'd0, 4'b1101},  // R6 0 at start is ignored
      {OP_STW,  16'h0001, 3'd0, 4'b1101},  // R5
      {OP_STW,  16'h0000, 3'd0, 4'b1101},  // R5
      {OP_STW,  16'h0001, 3'd4, 4'b0000}   // R5 stop, R9 PLL dropped
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic run_req = 0, slow_req = 0, wfi_req = 0, halt_req = 0;
   logic stop_wr_en = 0, stop_wr_bit = 0, pll_wr_en = 0, pll_wr_bit = 0;
   logic int_ack = 0, nmi = 0, wdg_en = 1'b1, osc_run = 1'b1;
   logic [NW-1:0] wake_lines = '0;
   logic cpu_en, per_en, div_sel, pll_sel, osc_en, wdg_cnt_en;
   logic [2:0] mode;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   pwr_mode_seq #(.N_WAKE(NW), .STAB_CYCLES(STAB)) i_pwr_mode_seq (
      .clk (clk), .rst_n (rst_n),
      .run_req_i (run_req), .slow_req_i (slow_req), .wfi_req_i (wfi_req),
      .halt_req_i (halt_req), .stop_wr_en_i (stop_wr_en), .stop_wr_bit_i (stop_wr_bit),
      .pll_wr_en_i (pll_wr_en), .pll_wr_bit_i (pll_wr_bit), .int_ack_i (int_ack),
      .wake_lines_i (wake_lines), .nmi_i (nmi), .wdg_enabled_i (wdg_en),
      .osc_running_i (osc_run), .cpu_clk_en_o (cpu_en), .per_clk_en_o (per_en),
      .clk_div_sel_o (div_sel), .pll_sel_o (pll_sel), .osc_en_o (osc_en),
      .wdg_cnt_en_o (wdg_cnt_en), .mode_o (mode)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one cycle of stimulus from a negedge, return at the next negedge
   task automatic op(input logic [3:0] code, input logic [15:0] arg);
      case (code)
         OP_PLL:  begin pll_wr_en = 1'b1; pll_wr_bit = arg[0]; end
         OP_SLOW: slow_req = 1'b1;
         OP_RUN:  run_req = 1'b1;
         OP_WFI:  wfi_req = 1'b1;
         OP_ACK:  int_ack = 1'b1;
         OP_WAKE: wake_lines = arg;
         OP_HALT: halt_req = 1'b1;
         OP_STW:  begin stop_wr_en = 1'b1; stop_wr_bit = arg[0]; end
         OP_NMI:  nmi = 1'b1;
         default: ;
      endcase
      @(negedge clk);
      run_req = 0; slow_req = 0; wfi_req = 0; halt_req = 0; int_ack = 0;
      stop_wr_en = 0; stop_wr_bit = 0; pll_wr_en = 0; pll_wr_bit = 0;
      wake_lines = '0;
      if (code == OP_NMI) nmi = 1'b0;
   endtask

   task automatic unlock();
      op(OP_STW, 16'h1);
      op(OP_STW, 16'h0);
      op(OP_STW, 16'h1);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 mode", 32'(mode), 32'd0);
      chk("R1 enables", {28'd0, cpu_en, per_en, osc_en, wdg_cnt_en}, 32'hF);
      chk("R1 div/pll", {30'd0, div_sel, pll_sel}, 32'd0);

      for (int v = 0; v < NV; v++) begin
         op(VEC[v][26:23], VEC[v][22:7]);
         chk($sformatf("vector %0d mode/cpu/per/div/pll (R2-table)", v),
             {25'd0, mode, cpu_en, per_en, div_sel, pll_sel}, {25'd0, VEC[v][6:0]});
      end

      // R5 / R10 in stop
      chk("R5 osc off in stop", 32'(osc_en), 32'd0);
      chk("R10 watchdog frozen in stop", 32'(wdg_cnt_en), 32'd0);
      osc_run = 1'b0;

      // R7 wake-up line, two sync stages plus the state register
      op(OP_WAKE, 16'h0200);
      @(negedge clk);
      chk("R7 still stop during sync", 32'(mode), 32'd4);
      @(negedge clk);
      chk("R7 wake mode", 32'(mode), 32'd5);
      chk("R7 osc on, clocks off", {29'd0, osc_en, cpu_en, per_en}, 32'b100);

      // R8 no progress without oscillation
      repeat (10) @(negedge clk);
      chk("R8 waits for oscillator", 32'(mode), 32'd5);
      osc_run = 1'b1;
      repeat (STAB - 1) @(negedge clk);
      chk("R8 one cycle before expiry", 32'(mode), 32'd5);
      @(negedge clk);
      chk("R8 resume run", 32'(mode), 32'd0);
      chk("R9 PLL off after stop", 32'(pll_sel), 32'd0);
      chk("R10 watchdog resumes", 32'(wdg_cnt_en), 32'd1);

      // R6 NMI high blocks stop, R5 then from slow
      op(OP_SLOW, 16'h0);
      nmi = 1'b1;
      unlock();
      chk("R6 NMI high blocks stop", 32'(mode), 32'd1);
      nmi = 1'b0;
      unlock();
      chk("R5 stop from slow", 32'(mode), 32'd4);
      osc_run = 1'b0;
      op(OP_NMI, 16'h0);
      repeat (2) @(negedge clk);
      chk("R7 NMI wakes", 32'(mode), 32'd5);
      osc_run = 1'b1;
      repeat (STAB) @(negedge clk);
      chk("R8 resume slow", {29'd0, mode}, 32'd1);
      chk("R8 divider back", 32'(div_sel), 32'd1);

      // R10 / R11 halt with watchdog disabled
      wdg_en = 1'b0;
      #1;
      chk("R10 follows enable flag", 32'(wdg_cnt_en), 32'd0);
      op(OP_HALT, 16'h0);
      chk("R11 halt entered", 32'(mode), 32'd6);
      chk("R11 all off", {26'd0, cpu_en, per_en, div_sel, pll_sel, osc_en, wdg_cnt_en}, 32'd0);
      op(OP_WAKE, 16'hFFFF);
      op(OP_NMI, 16'h0);
      op(OP_ACK, 16'h0);
      op(OP_RUN, 16'h0);
      unlock();
      repeat (3) @(negedge clk);
      chk("R11 halt ignores inputs", 32'(mode), 32'd6);

      // R1 reset leaves halt
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset exits halt", {29'd0, mode}, 32'd0);
      chk("R1 clocks after reset", {30'd0, cpu_en, osc_en}, 32'b11);

      summary();
      $finish;
   end
endmodule